// File: doc/BRIEF.md
# UART Receive Line Monitor

This block watches the receive pin of a UART and keeps two sticky status flags for the interrupt logic. The break flag reports a long unbroken low period on the line. A low period counts as a break once its length in bit periods reaches a threshold set by the character-length mode. The active-edge flag reports a transition on the pin in the direction that marks the start of activity. Both flags stay set until software clears them by writing a 1 to their bit.

The pin goes through a two-flop synchronizer. The optional receive inversion is applied to the synchronized samples, so both detectors see the logical line level. The low-run counter advances only on a one-cycle-per-bit-period sample strobe that the surrounding receiver supplies. A combined interrupt request is raised while either flag is set.

Top module: `uart_line_monitor`

## Requirements
- R1: After reset, `brk_flag`, `edge_flag` and `irq` are 0.
- R2: With `brk_en` high, `brk_flag` becomes 1 on the strobe that completes a run of consecutive logical-low strobe samples. The run is 11 samples long when `mode_9bit` is 0 and 12 when it is 1. After one sample fewer, the flag is still 0.
- R3: While `brk_en` is 0, a low run of any length leaves `brk_flag` at 0.
- R4: One continuous low run sets `brk_flag` only once. If the flag is cleared during the run, further low samples do not set it again. A logical-high sample restarts the count.
- R5: The active edge is a logical high-to-low change of the synchronized line. With `rx_inv`=0 this is a falling edge at the pin, and with `rx_inv`=1 it is a rising edge. A change in the other direction does not set `edge_flag`.
- R6: `edge_flag` can be set only while `two_wire` is 1.
- R7: A cycle with `clr_we`=1 clears `brk_flag` if `clr_data[1]`=1 and clears `edge_flag` if `clr_data[0]`=1. A 0 in a bit leaves that flag unchanged.
- R8: If a break is detected in the same cycle that software clears `brk_flag`, the flag ends up set.
- R9: `irq` is 1 exactly when at least one of the two flags is 1.
- R10: With `rx_inv`=1, the pin is inverted before break detection, so a run of high pin samples counts as a break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_pin | input | 1 | Raw receive pin, asynchronous |
| bit_tick | input | 1 | One-cycle strobe per bit period |
| mode_9bit | input | 1 | 1 selects 9-bit characters (break threshold 12) |
| brk_en | input | 1 | Break detection enable |
| rx_inv | input | 1 | Invert the received line |
| two_wire | input | 1 | Enables active-edge detection |
| clr_we | input | 1 | Write strobe for flag clearing |
| clr_data | input | 2 | Write-one-to-clear data: [1] break, [0] edge |
| brk_flag | output | 1 | Sticky break-detect flag |
| edge_flag | output | 1 | Sticky active-edge flag |
| irq | output | 1 | Interrupt request, OR of the flags |

## Verification
The hardest situation to reach is a hardware set of the break flag that lands in exactly the same cycle as a software clear. The stimulus drives the line low, issues one strobe fewer than the threshold, and then asserts the final strobe and the clear write on the same clock edge. A second hard case is a clear in the middle of a low run that is already saturated. The bench keeps issuing strobes after that clear to confirm the run does not set the flag again. Both cases are repeated for every combination of character mode, inversion and two-wire setting.

// File: rtl/uart_line_monitor.sv
module uart_line_monitor #(
  parameter int BRK_LEN8 = 11,
  parameter int BRK_LEN9 = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_pin,
  input  logic       bit_tick,
  input  logic       mode_9bit,
  input  logic       brk_en,
  input  logic       rx_inv,
  input  logic       two_wire,
  input  logic       clr_we,
  input  logic [1:0] clr_data,
  output logic       brk_flag,
  output logic       edge_flag,
  output logic       irq
);
  localparam int CW = $clog2(BRK_LEN9 + 1);

  logic [2:0]    sync_q;
  logic [CW-1:0] run_q;
  logic [CW-1:0] thr;
  logic          lvl, lvl_prev, brk_set, edge_set, brk_clr, edge_clr;

  assign lvl      = sync_q[1] ^ rx_inv;
  assign lvl_prev = sync_q[2] ^ rx_inv;
  assign thr      = mode_9bit ? CW'(BRK_LEN9) : CW'(BRK_LEN8);

  assign brk_set  = brk_en & bit_tick & ~lvl & (run_q == thr - CW'(1));
  assign edge_set = two_wire & lvl_prev & ~lvl;
  assign brk_clr  = clr_we & clr_data[1];
  assign edge_clr = clr_we & clr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 3'b111;
    end else begin
      sync_q <= {sync_q[1:0], rx_pin};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (bit_tick) begin
      if (lvl)             run_q <= '0;
      else if (run_q < thr) run_q <= run_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_flag  <= 1'b0;
      edge_flag <= 1'b0;
    end else begin
      brk_flag  <= brk_set  | (brk_flag  & ~brk_clr);
      edge_flag <= edge_set | (edge_flag & ~edge_clr);
    end
  end

  assign irq = brk_flag | edge_flag;
endmodule

module uart_line_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_tick,
  input logic       brk_en,
  input logic       two_wire,
  input logic       clr_we,
  input logic [1:0] clr_data,
  input logic       brk_flag,
  input logic       edge_flag,
  input logic       irq
);
  // R3
  brk_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_flag) |-> $past(brk_en));
  // R2
  brk_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_flag) |-> $past(bit_tick));
  // R6
  edge_needs_two_wire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(edge_flag) |-> $past(two_wire));
  // R7
  brk_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_flag && !(clr_we && clr_data[1])) |=> brk_flag);
  // R7
  edge_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_flag && !(clr_we && clr_data[0])) |=> edge_flag);
  // R9
  irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (brk_flag || edge_flag));
endmodule

bind uart_line_monitor uart_line_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .brk_en(brk_en),
  .two_wire(two_wire), .clr_we(clr_we), .clr_data(clr_data),
  .brk_flag(brk_flag), .edge_flag(edge_flag), .irq(irq)
);

// File: tb/sim_uart_line_monitor.sv
module sim_uart_line_monitor;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_pin = 1'b1, bit_tick = 1'b0, mode_9bit = 1'b0, brk_en = 1'b0;
  logic rx_inv = 1'b0, two_wire = 1'b0, clr_we = 1'b0;
  logic [1:0] clr_data = 2'b00;
  logic brk_flag, edge_flag, irq;
  int checks = 0, errors = 0;
  bit done = 0;

  uart_line_monitor u0 (
    .clk(clk), .rst_n(rst_n), .rx_pin(rx_pin), .bit_tick(bit_tick),
    .mode_9bit(mode_9bit), .brk_en(brk_en), .rx_inv(rx_inv),
    .two_wire(two_wire), .clr_we(clr_we), .clr_data(clr_data),
    .brk_flag(brk_flag), .edge_flag(edge_flag), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic line(logic l);
    @(negedge clk) rx_pin = l ^ rx_inv;
    repeat (4) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk) bit_tick = 1'b1;
    @(negedge clk) bit_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic clear(logic [1:0] d);
    @(negedge clk) begin clr_we = 1'b1; clr_data = d; end
    @(negedge clk) begin clr_we = 1'b0; clr_data = 2'b00; end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 brk", brk_flag, 1'b0);
    check("R1 edge", edge_flag, 1'b0);
    check("R1 irq", irq, 1'b0);
    rst_n = 1'b1;
    for (int cfg = 0; cfg < 8; cfg++) begin
      int thr;
      mode_9bit = cfg[0];
      rx_inv    = cfg[1];
      two_wire  = cfg[2];
      thr = mode_9bit ? 12 : 11;
      brk_en = 1'b1;
      line(1'b1);
      tick();
      clear(2'b11);
      check("R7 both cleared", irq, 1'b0);
      // active edge; with rx_inv the pin rises (R5, R10)
      line(1'b0);
      check("R5 R6 edge on active transition", edge_flag, two_wire);
      for (int i = 0; i < thr - 1; i++) tick();
      check("R2 one short of threshold", brk_flag, 1'b0);
      tick();
      check("R2 R10 break at threshold", brk_flag, 1'b1);
      check("R9 irq", irq, 1'b1);
      clear(2'b01);
      check("R7 edge clear keeps brk", brk_flag, 1'b1);
      check("R7 edge cleared", edge_flag, 1'b0);
      clear(2'b00);
      check("R7 zero write", brk_flag, 1'b1);
      clear(2'b10);
      check("R7 brk cleared", brk_flag, 1'b0);
      check("R9 irq low", irq, 1'b0);
      repeat (3) tick();
      check("R4 saturated run no reset", brk_flag, 1'b0);
      line(1'b1);
      tick();
      check("R5 inactive direction", edge_flag, 1'b0);
      // high sample restarted the count
      line(1'b0);
      clear(2'b11);
      for (int i = 0; i < thr; i++) tick();
      check("R4 restart after high", brk_flag, 1'b1);
      line(1'b1);
      tick();
      clear(2'b11);
      brk_en = 1'b0;
      line(1'b0);
      for (int i = 0; i < thr + 2; i++) tick();
      check("R3 disabled", brk_flag, 1'b0);
      line(1'b1);
      tick();
      brk_en = 1'b1;
      line(1'b0);
      for (int i = 0; i < thr - 1; i++) tick();
      @(negedge clk) begin bit_tick = 1'b1; clr_we = 1'b1; clr_data = 2'b10; end
      @(negedge clk) begin bit_tick = 1'b0; clr_we = 1'b0; clr_data = 2'b00; end
      check("R8 set wins", brk_flag, 1'b1);
      line(1'b1);
      tick();
      clear(2'b11);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule